// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Busy Arbitration

This block is a clocked two-port memory of 4096 words. A left port and a right port each carry their own address, write data, read data, active-low chip enable, read/write select (high for read, low for write) and active-low output enable. Either port may read or write any word in any cycle, fully independently of the other. The word width is a parameter, 8 or 9 bits, and 9 is the default.

When both ports are enabled on the same address in the same cycle, an arbiter picks one winner and raises the busy flag of the other port in that same cycle. A busy port cannot write, but it can still read. A mode input chooses between two roles. As the arbitration master, the block makes the busy decision itself. As a slave, it takes each port's busy from an external input, so that several devices placed side by side for a wider word all follow one decision.

Read data is registered. It appears one clock after a read request, together with a drive-enable flag that stands in for a three-state data bus.

Top module: `dual_port_busy_ram`

## Requirements
- R1: While reset is high, and at the first falling edge after reset is released with both chip enables high, the outputs `l_rvalid`, `r_rvalid`, `l_busy_out` and `r_busy_out` are all 0.
- R2: A port writes its `wdata` into the word at its `addr` at a rising clock edge only if, at that edge, `ce_n`=0, `rw_n`=0 and the port is not blocked. In every other case that word keeps its contents.
- R3: When a port has `ce_n`=0, `rw_n`=1 and `oe_n`=0 at an edge, then after that edge `rvalid`=1 and `rdata` holds the word at that address as it stood before any write at the same edge. In every other case `rvalid`=0 and `rdata`=0 after the edge.
- R4: A port that is writing (`ce_n`=0, `rw_n`=0) has `rvalid`=0 after that edge, even when its `oe_n`=0.
- R5: In master mode (`ms_master`=1), a busy output is 1 only in a cycle in which both ports have `ce_n`=0 on equal addresses. In such a cycle exactly one busy output is 1. If neither port held that address in the previous cycle, the right port is the one marked busy. Busy responds within the same cycle as the inputs.
- R6: In master mode, if one port was enabled on an address in the previous cycle and the other port then arrives on it, the arriving port is marked busy. It stays busy in every following cycle in which both ports remain on that address.
- R7: A port that is busy has its write suppressed, while the winning port's write completes. A busy port's read still returns data under R3.
- R8: In slave mode (`ms_master`=0), both busy outputs are 0. A port's `busy_in`=1 blocks that port's write, and reads proceed. In master mode the `busy_in` inputs have no effect.
- R9: If both ports write the same address at the same edge and neither port is blocked (this can happen only in slave mode), the left port's data is stored.
- R10: Simultaneous accesses by the two ports to different addresses both complete as if each port were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_master | input | 1 | 1 = arbitration master, 0 = slave taking external busy |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | WORD_W | Left write data |
| l_rdata | output | WORD_W | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data drive-enable |
| l_busy_out | output | 1 | Left busy flag (master mode) |
| l_busy_in | input | 1 | Left external busy (slave mode) |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | WORD_W | Right write data |
| r_rdata | output | WORD_W | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data drive-enable |
| r_busy_out | output | 1 | Right busy flag (master mode) |
| r_busy_in | input | 1 | Right external busy (slave mode) |

## Verification
The case of interest is a cycle in which both ports enable the same address while a write and a busy decision coincide. The winner's write has to land, the loser's write has to vanish, and a loser that is reading has to see the contents from before the edge. The bench provokes this with directed collisions: simultaneous arrival, an arrival on an address the other port already holds, write against read, and unblocked double writes in slave mode. It follows these with long random traffic over a small address window, where collisions are frequent. On every clock, a behavioural reference memory with its own ownership tracking predicts both busy flags in the same cycle, and then the read data and drive-enables after the edge. Later reads of the contested words show whether a suppressed write left any trace.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int DPR_ADDR_W = 12;

    typedef enum logic [0:0] {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // decoded, active-high view of one port's control pins
    typedef struct packed {
        logic en;
        logic wr;
        logic oe;
    } port_ctl_t;

    function automatic port_ctl_t decode_ctl(input logic ce_n, input logic rw_n,
                                             input logic oe_n);
        port_ctl_t c;
        c.en = ~ce_n;
        c.wr = ~rw_n;
        c.oe = ~oe_n;
        return c;
    endfunction

    function automatic logic is_read(input port_ctl_t c);
        return c.en & ~c.wr & c.oe;
    endfunction

    function automatic logic is_write(input port_ctl_t c, input logic blocked);
        return c.en & c.wr & ~blocked;
    endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int ADDR_W = DPR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master,
    input  logic              en_l,
    input  logic              en_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              busy_l,
    output logic              busy_r
);

    logic              prev_en_l, prev_en_r;
    logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
    side_e             prev_win;

    logic  hit;
    logic  held_l, held_r;
    side_e win;

    always_comb begin
        hit    = en_l && en_r && (addr_l == addr_r);
        held_l = prev_en_l && (prev_addr_l == addr_l);
        held_r = prev_en_r && (prev_addr_r == addr_r);
        if (held_l && held_r)
            win = prev_win;
        else if (held_r)
            win = SIDE_RIGHT;
        else
            win = SIDE_LEFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en_l   <= 1'b0;
            prev_en_r   <= 1'b0;
            prev_addr_l <= '0;
            prev_addr_r <= '0;
            prev_win    <= SIDE_LEFT;
        end else begin
            prev_en_l   <= en_l;
            prev_en_r   <= en_r;
            prev_addr_l <= addr_l;
            prev_addr_r <= addr_r;
            if (hit)
                prev_win <= win;
        end
    end

    assign busy_l = master && hit && (win == SIDE_RIGHT);
    assign busy_r = master && hit && (win == SIDE_LEFT);

endmodule

// File: rtl/dpr_mem_array.sv
module dpr_mem_array #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              we_l,
    input  logic              re_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [WORD_W-1:0] wd_l,
    output logic [WORD_W-1:0] q_l,
    input  logic              we_r,
    input  logic              re_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [WORD_W-1:0] wd_r,
    output logic [WORD_W-1:0] q_r
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    // right first, then left: an unblocked double write keeps left data
    always_ff @(posedge clk) begin
        if (we_r)
            store[addr_r] <= wd_r;
        if (we_l)
            store[addr_l] <= wd_l;
    end

    always_ff @(posedge clk) begin
        if (re_l)
            q_l <= store[addr_l];
        if (re_r)
            q_r <= store[addr_r];
    end

endmodule

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
    import dpr_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  port_ctl_t         ctl,
    input  logic              blocked,
    input  logic [WORD_W-1:0] q,
    output logic              we,
    output logic              re,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    assign we = is_write(ctl, blocked);
    assign re = is_read(ctl);

    always_ff @(posedge clk) begin
        if (rst)
            rvalid <= 1'b0;
        else
            rvalid <= re;
    end

    assign rdata = rvalid ? q : '0;

endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = DPR_ADDR_W,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_master,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_out,
    input  logic              l_busy_in,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_out,
    input  logic              r_busy_in
);

    localparam int NPORT = 2;

    port_ctl_t         ctl_v   [NPORT];
    logic              blk_v   [NPORT];
    logic              bin_v   [NPORT];
    logic              bsy_v   [NPORT];
    logic [WORD_W-1:0] q_v     [NPORT];
    logic              we_v    [NPORT];
    logic              re_v    [NPORT];
    logic [WORD_W-1:0] rd_v    [NPORT];
    logic              rv_v    [NPORT];

    assign ctl_v[0] = decode_ctl(l_ce_n, l_rw_n, l_oe_n);
    assign ctl_v[1] = decode_ctl(r_ce_n, r_rw_n, r_oe_n);
    assign bin_v[0] = l_busy_in;
    assign bin_v[1] = r_busy_in;

    dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .master (ms_master),
        .en_l   (ctl_v[0].en),
        .en_r   (ctl_v[1].en),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .busy_l (bsy_v[0]),
        .busy_r (bsy_v[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign blk_v[p] = ms_master ? bsy_v[p] : bin_v[p];

        dpr_port_ctl #(.WORD_W(WORD_W)) u_ctl (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl_v[p]),
            .blocked (blk_v[p]),
            .q       (q_v[p]),
            .we      (we_v[p]),
            .re      (re_v[p]),
            .rdata   (rd_v[p]),
            .rvalid  (rv_v[p])
        );
    end

    dpr_mem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk    (clk),
        .we_l   (we_v[0]),
        .re_l   (re_v[0]),
        .addr_l (l_addr),
        .wd_l   (l_wdata),
        .q_l    (q_v[0]),
        .we_r   (we_v[1]),
        .re_r   (re_v[1]),
        .addr_r (r_addr),
        .wd_r   (r_wdata),
        .q_r    (q_v[1])
    );

    assign l_rdata    = rd_v[0];
    assign l_rvalid   = rv_v[0];
    assign r_rdata    = rd_v[1];
    assign r_rvalid   = rv_v[1];
    assign l_busy_out = bsy_v[0];
    assign r_busy_out = bsy_v[1];

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              ms_master,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [WORD_W-1:0] l_rdata,
    input logic              l_rvalid,
    input logic              l_busy_out,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [WORD_W-1:0] r_rdata,
    input logic              r_rvalid,
    input logic              r_busy_out
);

    logic hit, rd_l, rd_r, wr_l, wr_r;
    assign hit  = !l_ce_n && !r_ce_n && (l_addr == r_addr);
    assign rd_l = !l_ce_n && l_rw_n && !l_oe_n;
    assign rd_r = !r_ce_n && r_rw_n && !r_oe_n;
    assign wr_l = !l_ce_n && !l_rw_n;
    assign wr_r = !r_ce_n && !r_rw_n;

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_out && r_busy_out)); // R5
    AST_BUSY_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (l_busy_out || r_busy_out) |-> (ms_master && hit)); // R5
    AST_HIT_FLAGS_ONE: assert property (@(posedge clk) disable iff (rst)
        (ms_master && hit) |-> (l_busy_out || r_busy_out)); // R5
    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ms_master |-> (!l_busy_out && !r_busy_out)); // R8
    AST_READ_VALID_L: assert property (@(posedge clk) disable iff (rst)
        rd_l |=> l_rvalid); // R3
    AST_READ_VALID_R: assert property (@(posedge clk) disable iff (rst)
        rd_r |=> r_rvalid); // R3
    AST_WRITE_NO_DRIVE_L: assert property (@(posedge clk) disable iff (rst)
        wr_l |=> !l_rvalid); // R4
    AST_WRITE_NO_DRIVE_R: assert property (@(posedge clk) disable iff (rst)
        wr_r |=> !r_rvalid); // R4
    AST_IDLE_ZERO_L: assert property (@(posedge clk) disable iff (rst)
        !l_rvalid |-> (l_rdata == '0)); // R3
    AST_IDLE_ZERO_R: assert property (@(posedge clk) disable iff (rst)
        !r_rvalid |-> (r_rdata == '0)); // R3
    AST_OWNER_HOLD_R: assert property (@(posedge clk) disable iff (rst)
        (ms_master && r_busy_out) |=>
        (!(ms_master && hit && $stable(l_addr) && $stable(r_addr)) || r_busy_out)); // R6
    AST_OWNER_HOLD_L: assert property (@(posedge clk) disable iff (rst)
        (ms_master && l_busy_out) |=>
        (!(ms_master && hit && $stable(l_addr) && $stable(r_addr)) || l_busy_out)); // R6

endmodule

bind dual_port_busy_ram dpr_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/dual_port_busy_ram_bench.sv
module dual_port_busy_ram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int W  = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ms_master = 1'b1;
    logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_busy_in = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic [W-1:0]  l_wdata = '0;
    logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_busy_in = 1'b0;
    logic [AW-1:0] r_addr = '0;
    logic [W-1:0]  r_wdata = '0;
    logic [W-1:0]  l_rdata, r_rdata;
    logic          l_rvalid, r_rvalid, l_busy_out, r_busy_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_port_busy_ram #(.ADDR_W(AW), .WORD_W(W)) u_dual_port_busy_ram (
        .clk(clk), .rst(rst), .ms_master(ms_master),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .l_busy_out(l_busy_out), .l_busy_in(l_busy_in),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
        .r_busy_out(r_busy_out), .r_busy_in(r_busy_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] ref_mem [64];
    bit m_pl_on = 0, m_pr_on = 0;
    int m_pl_a = 0, m_pr_a = 0;
    int m_win = 0; // 0 left, 1 right

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic setl(input bit ce, input bit rw, input bit oe, input int a, input int d);
        l_ce_n = ce; l_rw_n = rw; l_oe_n = oe;
        l_addr = AW'(a); l_wdata = W'(d);
    endtask

    task automatic setr(input bit ce, input bit rw, input bit oe, input int a, input int d);
        r_ce_n = ce; r_rw_n = rw; r_oe_n = oe;
        r_addr = AW'(a); r_wdata = W'(d);
    endtask

    // one clock: busy checked in-cycle, read results checked after the edge
    task automatic run_cycle(input string tb, input string tr);
        bit lon, ron, coll, lh, rh, eb_l, eb_r, bk_l, bk_r, wl, wr, rl, rr;
        int win;
        logic [W-1:0] dl, dr;
        #1;
        lon  = !l_ce_n;
        ron  = !r_ce_n;
        coll = lon && ron && (l_addr == r_addr);
        win  = 0;
        if (coll) begin
            lh = m_pl_on && (m_pl_a == int'(l_addr));
            rh = m_pr_on && (m_pr_a == int'(r_addr));
            if (lh && rh) win = m_win;
            else if (rh) win = 1;
        end
        eb_l = ms_master && coll && (win == 1);
        eb_r = ms_master && coll && (win == 0);
        check(tb, "l_busy_out", 32'(l_busy_out), 32'(eb_l));
        check(tb, "r_busy_out", 32'(r_busy_out), 32'(eb_r));
        bk_l = ms_master ? eb_l : l_busy_in;
        bk_r = ms_master ? eb_r : r_busy_in;
        wl = lon && !l_rw_n && !bk_l;
        wr = ron && !r_rw_n && !bk_r;
        rl = lon && l_rw_n && !l_oe_n;
        rr = ron && r_rw_n && !r_oe_n;
        dl = rl ? ref_mem[l_addr[5:0]] : '0;
        dr = rr ? ref_mem[r_addr[5:0]] : '0;
        @(posedge clk);
        if (wr) ref_mem[r_addr[5:0]] = r_wdata;
        if (wl) ref_mem[l_addr[5:0]] = l_wdata;
        m_pl_on = lon; m_pl_a = int'(l_addr);
        m_pr_on = ron; m_pr_a = int'(r_addr);
        if (coll) m_win = win;
        @(negedge clk);
        check(tr, "l_rvalid", 32'(l_rvalid), 32'(rl));
        check(tr, "l_rdata", 32'(l_rdata), 32'(dl));
        check(tr, "r_rvalid", 32'(r_rvalid), 32'(rr));
        check(tr, "r_rdata", 32'(r_rdata), 32'(dr));
    endtask

    task automatic idle_both;
        setl(1, 1, 1, 0, 0);
        setr(1, 1, 1, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1", "l_rvalid", 32'(l_rvalid), 0);
        check("R1", "r_busy_out", 32'(r_busy_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "l_rvalid", 32'(l_rvalid), 0);
        check("R1", "r_rvalid", 32'(r_rvalid), 0);
        check("R1", "l_busy_out", 32'(l_busy_out), 0);
        check("R1", "r_busy_out", 32'(r_busy_out), 0);

        // R10 / R2: fill the window from both ports at once, different words
        for (int i = 0; i < 32; i++) begin
            setl(0, 0, 1, i, 9'h100 + i * 3);
            setr(0, 0, 0, i + 32, 9'h055 ^ (i * 7));
            run_cycle("R10", "R4");
        end
        // R10 / R3: read them back on both ports simultaneously
        for (int i = 0; i < 32; i++) begin
            setl(0, 1, 0, i + 32, 0);
            setr(0, 1, 0, i, 0);
            run_cycle("R10", "R3");
        end
        // R3: output enable high or chip enable high gives no data
        setl(0, 1, 1, 3, 0); setr(1, 1, 0, 4, 0); run_cycle("R3", "R3");
        // R2: chip enable high with write select low must not write
        setl(1, 0, 0, 6, 9'h1AA); setr(1, 1, 1, 0, 0); run_cycle("R2", "R2");
        setl(0, 1, 0, 6, 0); idle_r(); run_cycle("R2", "R2");

        // R5 / R7: simultaneous collision, both write -> left wins
        setl(0, 0, 1, 5, 9'h0F1); setr(0, 0, 1, 5, 9'h1E2); run_cycle("R5", "R7");
        idle_both(); run_cycle("R5", "R7");
        setl(0, 1, 0, 5, 0); run_cycle("R7", "R7");

        // R6: right holds address 7, left arrives and stays busy
        idle_both(); run_cycle("R6", "R6");
        setr(0, 1, 0, 7, 0); run_cycle("R6", "R6");
        setl(0, 0, 1, 7, 9'h133); run_cycle("R6", "R6");
        run_cycle("R6", "R6");
        setr(0, 1, 0, 8, 0); setl(0, 0, 1, 7, 9'h144); run_cycle("R6", "R6");
        idle_both(); setl(0, 1, 0, 7, 0); run_cycle("R6", "R2");

        // R7: left write wins, busy right still reads old data
        idle_both(); run_cycle("R7", "R7");
        setl(0, 0, 1, 9, 9'h0AB); setr(0, 1, 0, 9, 0); run_cycle("R7", "R7");
        idle_both(); setr(0, 1, 0, 9, 0); run_cycle("R7", "R7");

        // R8: slave mode, busy outputs silent, external busy blocks writes
        ms_master = 1'b0;
        l_busy_in = 1'b1;
        setl(0, 0, 1, 10, 9'h1FF); setr(0, 1, 0, 10, 0); run_cycle("R8", "R8");
        setl(0, 1, 0, 10, 0); idle_r(); run_cycle("R8", "R8");
        setr(0, 1, 0, 11, 0); run_cycle("R8", "R8");
        l_busy_in = 1'b0;
        // R9: unblocked double write to one word keeps left data
        setl(0, 0, 1, 12, 9'h011); setr(0, 0, 1, 12, 9'h022); run_cycle("R9", "R9");
        idle_both(); setr(0, 1, 0, 12, 0); run_cycle("R9", "R9");
        // R8: external busy is ignored in master mode
        ms_master = 1'b1;
        r_busy_in = 1'b1;
        idle_both(); setr(0, 0, 1, 13, 9'h0C3); run_cycle("R8", "R8");
        idle_both(); setr(0, 1, 0, 13, 0); run_cycle("R8", "R8");
        r_busy_in = 1'b0;

        // R10: random mixed traffic over a small window
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rv;
            rv = $urandom();
            if (n % 500 == 0) ms_master = rv[31];
            l_busy_in = rv[30] & rv[29];
            r_busy_in = rv[28] & rv[27];
            setl(rv[0] & rv[1], rv[2], rv[3] & rv[4], int'(rv[8:5]), int'(rv[17:9]));
            setr(rv[18] & rv[19], rv[20], rv[21] & rv[22], int'(rv[26:23]), int'(rv[17:9] ^ 9'h15A));
            run_cycle("R10", "R10");
        end
        idle_both();
        ms_master = 1'b1;
        // sweep read-back of the random window
        for (int i = 0; i < 16; i++) begin
            setl(0, 1, 0, i, 0); setr(0, 1, 0, 15 - i, 0);
            run_cycle("R10", "R2");
        end
        finish_run();
    end

    task automatic idle_r;
        setr(1, 1, 1, 0, 0);
    endtask

endmodule